// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged Data Cache

This block is a direct-mapped, write-back first-level data cache for a 32-bit address space. A load or store is accepted with its virtual address, and the line lookup into the tag and data arrays starts from that virtual address at once. The physical address arrives on its own valid signal in the same cycle or later, from an address translator outside the block. The stored tag is then compared against the physical address.

Lines are 64 bytes and there are 512 of them, so the index covers address bits [14:6]. Pages are 8 KB, so the tag is physical bits [31:13]. Bits [14:13] therefore take part in both the virtual index and the physical tag. These two bits are the page color. The block refuses any access whose virtual color and physical color differ, and it reports that case on a one-cycle fault output.

On a miss, the block first writes back a dirty victim line, then fetches the new line over a simple beat-wise memory port, and finally completes the access as a hit. The CPU side is held by a stall signal from acceptance until the controller is idle again.

Top module: `vipt_dcache`

## Requirements
- R1: After reset, `cpu_stall`, `cpu_resp`, `alias_fault`, `mem_wr_valid` and `mem_fill_ready` are all low, and every line is invalid.
- R2: A load that hits raises `cpu_resp` for exactly one cycle, in the cycle after the one in which `pa_valid` was sampled. `cpu_rdata` then holds the 32-bit word selected by VA[5:2] of the line.
- R3: A store that hits merges the bytes whose `cpu_be` bit is set (bit n covers data bits [8n+7:8n]) into the line, marks the line dirty, and produces no memory write.
- R4: The line is selected by VA[14:6]. A hit requires the line to be valid and its stored tag to equal PA[31:13]. Two virtual addresses of equal color that translate to the same physical address therefore see each other's stores.
- R5: If VA[14:13] differs from PA[14:13] when `pa_valid` is sampled, the access is dropped. `alias_fault` pulses for one cycle with no `cpu_resp`, and no line, tag, valid or dirty state changes.
- R6: A miss fetches the line as 16 beats of 32 bits. `mem_fill_ready` is held high with `mem_addr` set to the line base (PA[31:6], low six bits zero). A beat transfers on each clock with `mem_rd_valid` and `mem_fill_ready` both high, beats fill word 0 up to word 15, and the pending access then completes as a hit.
- R7: A miss whose victim line is valid and dirty first writes the victim back as 16 beats of 32 bits, word 0 first. `mem_addr` holds the victim base {stored tag, VA[12:6], 6'b0}, and a beat moves on each clock with `mem_wr_valid` and `mem_wr_ready` high, with address and data held while not accepted. The fill starts only after the last beat. A clean victim is not written back.
- R8: `cpu_stall` is high from the cycle after a request is accepted until the controller returns to idle. `cpu_req` is ignored while `cpu_stall` is high.
- R9: A store miss allocates: the line is fetched, the store bytes are merged, and the line is left valid and dirty.
- R10: Every load returns the same word as a flat byte-addressed memory to which all completed stores have been applied in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Access request, accepted when `cpu_stall` is low |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_vaddr | input | 32 | Virtual byte address of the access |
| cpu_wdata | input | 32 | Store data |
| cpu_be | input | 4 | Store byte enables |
| cpu_stall | output | 1 | Access in progress; new requests ignored |
| cpu_resp | output | 1 | One-cycle completion pulse for a load or store |
| cpu_rdata | output | 32 | Load data, valid with `cpu_resp` |
| pa_valid | input | 1 | Physical address valid for the pending access |
| pa_addr | input | 32 | Translated physical byte address |
| alias_fault | output | 1 | One-cycle pulse: color bits disagree, access dropped |
| mem_addr | output | 32 | Line base address for writeback or fill |
| mem_wr_valid | output | 1 | Writeback beat valid |
| mem_wr_ready | input | 1 | Memory accepts a writeback beat |
| mem_wdata | output | 32 | Writeback beat data |
| mem_fill_ready | output | 1 | Fill in progress, ready for a beat |
| mem_rd_valid | input | 1 | Fill beat valid |
| mem_rd_data | input | 32 | Fill beat data |

## Verification
Each kind of internal fault shows up in a different place. A wrong tag, valid or dirty bit shows as a load result that disagrees with the flat memory model. It can also show as a writeback that is missing or extra, which appears on the memory port at the next conflicting miss to that index, usually a few accesses after the fault. A wrong merge or beat order is exposed when the evicted line is fetched back and read word by word. A color check that accepts a mismatch, or a fault that still changes state, is seen as soon as the same physical word is read again through a correctly colored address. Hit latency and the single-cycle pulses are measured against the cycle in which the physical address was presented.

// File: rtl/vipt_dcache_pkg.sv
package vipt_dcache_pkg;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_COMPARE   = 3'd1,
    ST_WRITEBACK = 3'd2,
    ST_FILL      = 3'd3,
    ST_RESPOND   = 3'd4
  } dc_state_e;

endpackage

// File: rtl/dcache_tag_store.sv
module dcache_tag_store #(
  parameter int LINES = 512,
  parameter int IDX_W = 9,
  parameter int TAG_W = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic             rd_dirty,
  output logic [TAG_W-1:0] rd_tag,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             wr_dirty
);

  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] dirty_q;
  logic [TAG_W-1:0] tag_mem [LINES];

  // valid and dirty need a defined state after reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= 1'b1;
      dirty_q[wr_idx] <= wr_dirty;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx] <= wr_tag;
    end
  end

  // registered read, started from the virtual index
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_dirty <= 1'b0;
    end else if (rd_en) begin
      rd_valid <= valid_q[rd_idx];
      rd_dirty <= dirty_q[rd_idx];
    end
  end

  always_ff @(posedge clk) begin
    if (rd_en) begin
      rd_tag <= tag_mem[rd_idx];
    end
  end

  // a dirty line read back must also be valid
  AST_DIRTY_IMPLIES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rd_dirty |-> rd_valid); // R3

endmodule

// File: rtl/dcache_line_store.sv
module dcache_line_store #(
  parameter int LINES  = 512,
  parameter int IDX_W  = 9,
  parameter int LINE_W = 512
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [LINE_W-1:0] rd_line,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [LINE_W-1:0] wr_line
);

  logic [LINE_W-1:0] line_mem [LINES];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      line_mem[wr_idx] <= wr_line;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_en) begin
      rd_line <= line_mem[rd_idx];
    end
  end

endmodule

// File: rtl/dcache_ctrl.sv
module dcache_ctrl
  import vipt_dcache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int LINES      = 512,
  parameter int PAGE_BYTES = 8192
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cpu_req,
  input  logic                cpu_we,
  input  logic [ADDR_W-1:0]   cpu_vaddr,
  input  logic [WORD_W-1:0]   cpu_wdata,
  input  logic [WORD_W/8-1:0] cpu_be,
  output logic                cpu_stall,
  output logic                cpu_resp,
  output logic [WORD_W-1:0]   cpu_rdata,
  input  logic                pa_valid,
  input  logic [ADDR_W-1:0]   pa_addr,
  output logic                alias_fault,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic                mem_wr_valid,
  input  logic                mem_wr_ready,
  output logic [WORD_W-1:0]   mem_wdata,
  output logic                mem_fill_ready,
  input  logic                mem_rd_valid,
  input  logic [WORD_W-1:0]   mem_rd_data,
  // tag store
  output logic                                     tag_rd_en,
  output logic [$clog2(LINES)-1:0]                 tag_rd_idx,
  input  logic                                     tag_rd_valid,
  input  logic                                     tag_rd_dirty,
  input  logic [ADDR_W-$clog2(PAGE_BYTES)-1:0]     tag_rd_tag,
  output logic                                     tag_wr_en,
  output logic [$clog2(LINES)-1:0]                 tag_wr_idx,
  output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0]     tag_wr_tag,
  output logic                                     tag_wr_dirty,
  // line store
  input  logic [LINE_BYTES*8-1:0]                  line_rd_line,
  output logic                                     line_wr_en,
  output logic [LINE_BYTES*8-1:0]                  line_wr_line
);

  localparam int OFS_W   = $clog2(LINE_BYTES);
  localparam int IDX_W   = $clog2(LINES);
  localparam int POFS_W  = $clog2(PAGE_BYTES);
  localparam int TAG_W   = ADDR_W - POFS_W;
  localparam int LINE_W  = LINE_BYTES * 8;
  localparam int BE_W    = WORD_W / 8;
  localparam int BYTE_W  = $clog2(BE_W);
  localparam int BEATS   = LINE_W / WORD_W;
  localparam int BEAT_W  = $clog2(BEATS);
  localparam int LADDR_W = ADDR_W - OFS_W;
  localparam int COLOR_W = IDX_W + OFS_W - POFS_W;
  localparam int LOW_W   = POFS_W - OFS_W;

  dc_state_e state_q, state_d;

  logic [IDX_W-1:0]   va_idx_q;
  logic [BEAT_W-1:0]  va_word_q;
  logic               we_q;
  logic [WORD_W-1:0]  wdata_q;
  logic [BE_W-1:0]    be_q;
  logic [LADDR_W-1:0] pa_line_q;
  logic [BEAT_W-1:0]  beat_q, beat_d;
  logic [WORD_W-1:0]  rdata_q;
  logic               fault_q, fault_d;
  logic [LINE_W-1:0]  fill_buf_q;

  logic accept, pa_take, color_ok, tag_hit, beat_last;
  logic wb_beat, fill_beat, fill_done, hit_store, rdata_en;
  logic [LINE_W-1:0] fill_line, base_line, merged_line;
  logic unused_addr_bits;

  function automatic logic [LINE_W-1:0] merge_word(
    input logic [LINE_W-1:0] line,
    input logic [BEAT_W-1:0] word,
    input logic [WORD_W-1:0] data,
    input logic [BE_W-1:0]   be
  );
    logic [LINE_W-1:0] res;
    res = line;
    for (int b = 0; b < BE_W; b++) begin
      if (be[b]) res[word*WORD_W + b*8 +: 8] = data[b*8 +: 8];
    end
    return res;
  endfunction

  // color bits: top of the virtual index against the same physical bits
  generate
    if (COLOR_W > 0) begin : g_color
      assign color_ok = (va_idx_q[IDX_W-1 -: COLOR_W] ==
                         pa_addr[IDX_W+OFS_W-1 -: COLOR_W]);
    end else begin : g_no_color
      assign color_ok = 1'b1;
    end
  endgenerate

  assign unused_addr_bits = ^{cpu_vaddr[ADDR_W-1:IDX_W+OFS_W],
                              cpu_vaddr[BYTE_W-1:0], pa_addr[OFS_W-1:0]};

  assign accept    = (state_q == ST_IDLE) && cpu_req;
  assign pa_take   = (state_q == ST_COMPARE) && pa_valid;
  assign tag_hit   = tag_rd_valid && (tag_rd_tag == pa_addr[ADDR_W-1:POFS_W]);
  assign beat_last = (beat_q == BEAT_W'(BEATS - 1));
  assign wb_beat   = (state_q == ST_WRITEBACK) && mem_wr_ready;
  assign fill_beat = (state_q == ST_FILL) && mem_rd_valid;
  assign fill_done = fill_beat && beat_last;
  assign hit_store = pa_take && color_ok && tag_hit && we_q;

  always_comb begin
    fill_line = fill_buf_q;
    fill_line[beat_q*WORD_W +: WORD_W] = mem_rd_data;
  end

  assign base_line   = (state_q == ST_FILL) ? fill_line : line_rd_line;
  assign merged_line = merge_word(base_line, va_word_q, wdata_q, be_q);
  assign rdata_en    = (pa_take && color_ok && tag_hit && !we_q) || fill_done;

  // next state
  always_comb begin
    state_d = state_q;
    fault_d = 1'b0;
    beat_d  = beat_q;
    unique case (state_q)
      ST_IDLE: if (cpu_req) state_d = ST_COMPARE;
      ST_COMPARE: begin
        if (pa_valid) begin
          if (!color_ok) begin
            state_d = ST_IDLE;
            fault_d = 1'b1;
          end else if (tag_hit) begin
            state_d = ST_RESPOND;
          end else if (tag_rd_valid && tag_rd_dirty) begin
            state_d = ST_WRITEBACK;
          end else begin
            state_d = ST_FILL;
          end
        end
      end
      ST_WRITEBACK: begin
        if (wb_beat) begin
          beat_d = beat_q + 1'b1;
          if (beat_last) state_d = ST_FILL;
        end
      end
      ST_FILL: begin
        if (fill_beat) begin
          beat_d = beat_q + 1'b1;
          if (beat_last) state_d = ST_RESPOND;
        end
      end
      ST_RESPOND: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      fault_q <= 1'b0;
      beat_q  <= '0;
      we_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      fault_q <= fault_d;
      beat_q  <= beat_d;
      if (accept) we_q <= cpu_we;
    end
  end

  // datapath registers, clock-enabled, no reset
  always_ff @(posedge clk) begin
    if (accept) begin
      va_idx_q  <= cpu_vaddr[IDX_W+OFS_W-1:OFS_W];
      va_word_q <= cpu_vaddr[OFS_W-1:BYTE_W];
      wdata_q   <= cpu_wdata;
      be_q      <= cpu_be;
    end
    if (pa_take) pa_line_q <= pa_addr[ADDR_W-1:OFS_W];
    if (rdata_en) rdata_q <= base_line[va_word_q*WORD_W +: WORD_W];
    if (fill_beat) fill_buf_q[beat_q*WORD_W +: WORD_W] <= mem_rd_data;
  end

  // array ports
  assign tag_rd_en    = accept;
  assign tag_rd_idx   = cpu_vaddr[IDX_W+OFS_W-1:OFS_W];
  assign tag_wr_en    = hit_store || fill_done;
  assign tag_wr_idx   = va_idx_q;
  assign tag_wr_dirty = we_q;
  assign tag_wr_tag   = (state_q == ST_FILL) ? pa_line_q[LADDR_W-1 -: TAG_W]
                                             : pa_addr[ADDR_W-1:POFS_W];
  assign line_wr_en   = tag_wr_en;
  assign line_wr_line = we_q ? merged_line : fill_line;

  // memory port
  always_comb begin
    unique case (state_q)
      ST_WRITEBACK: mem_addr = {tag_rd_tag, va_idx_q[LOW_W-1:0], {OFS_W{1'b0}}};
      ST_FILL:      mem_addr = {pa_line_q, {OFS_W{1'b0}}};
      default:      mem_addr = '0;
    endcase
  end
  assign mem_wr_valid   = (state_q == ST_WRITEBACK);
  assign mem_wdata      = line_rd_line[beat_q*WORD_W +: WORD_W];
  assign mem_fill_ready = (state_q == ST_FILL);

  // CPU port
  assign cpu_stall   = (state_q != ST_IDLE);
  assign cpu_resp    = (state_q == ST_RESPOND);
  assign cpu_rdata   = rdata_q;
  assign alias_fault = fault_q;

  AST_FAULT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    alias_fault |=> !alias_fault); // R5
  AST_FAULT_NO_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    alias_fault |-> !cpu_resp); // R5
  AST_FAULT_AFTER_PA: assert property (@(posedge clk) disable iff (!rst_n)
    alias_fault |-> $past(pa_valid)); // R5
  AST_RESP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_resp |=> !cpu_resp); // R2
  AST_STALL_COVERS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_resp |-> cpu_stall); // R8
  AST_WB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid && !mem_wr_ready) |=>
      (mem_wr_valid && $stable(mem_wdata) && $stable(mem_addr))); // R7
  AST_FILL_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_fill_ready |=> (!mem_fill_ready || $stable(mem_addr))); // R6

endmodule

// File: rtl/vipt_dcache.sv
module vipt_dcache
  import vipt_dcache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int LINES      = 512,
  parameter int PAGE_BYTES = 8192
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cpu_req,
  input  logic                cpu_we,
  input  logic [ADDR_W-1:0]   cpu_vaddr,
  input  logic [WORD_W-1:0]   cpu_wdata,
  input  logic [WORD_W/8-1:0] cpu_be,
  output logic                cpu_stall,
  output logic                cpu_resp,
  output logic [WORD_W-1:0]   cpu_rdata,
  input  logic                pa_valid,
  input  logic [ADDR_W-1:0]   pa_addr,
  output logic                alias_fault,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic                mem_wr_valid,
  input  logic                mem_wr_ready,
  output logic [WORD_W-1:0]   mem_wdata,
  output logic                mem_fill_ready,
  input  logic                mem_rd_valid,
  input  logic [WORD_W-1:0]   mem_rd_data
);

  localparam int IDX_W  = $clog2(LINES);
  localparam int TAG_W  = ADDR_W - $clog2(PAGE_BYTES);
  localparam int LINE_W = LINE_BYTES * 8;

  logic              tag_rd_en, tag_rd_valid, tag_rd_dirty;
  logic [IDX_W-1:0]  tag_rd_idx, tag_wr_idx;
  logic [TAG_W-1:0]  tag_rd_tag, tag_wr_tag;
  logic              tag_wr_en, tag_wr_dirty;
  logic [LINE_W-1:0] line_rd_line, line_wr_line;
  logic              line_wr_en;

  dcache_tag_store #(
    .LINES (LINES),
    .IDX_W (IDX_W),
    .TAG_W (TAG_W)
  ) u_tags (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (tag_rd_en),
    .rd_idx   (tag_rd_idx),
    .rd_valid (tag_rd_valid),
    .rd_dirty (tag_rd_dirty),
    .rd_tag   (tag_rd_tag),
    .wr_en    (tag_wr_en),
    .wr_idx   (tag_wr_idx),
    .wr_tag   (tag_wr_tag),
    .wr_dirty (tag_wr_dirty)
  );

  dcache_line_store #(
    .LINES  (LINES),
    .IDX_W  (IDX_W),
    .LINE_W (LINE_W)
  ) u_lines (
    .clk     (clk),
    .rd_en   (tag_rd_en),
    .rd_idx  (tag_rd_idx),
    .rd_line (line_rd_line),
    .wr_en   (line_wr_en),
    .wr_idx  (tag_wr_idx),
    .wr_line (line_wr_line)
  );

  dcache_ctrl #(
    .ADDR_W     (ADDR_W),
    .WORD_W     (WORD_W),
    .LINE_BYTES (LINE_BYTES),
    .LINES      (LINES),
    .PAGE_BYTES (PAGE_BYTES)
  ) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .cpu_req        (cpu_req),
    .cpu_we         (cpu_we),
    .cpu_vaddr      (cpu_vaddr),
    .cpu_wdata      (cpu_wdata),
    .cpu_be         (cpu_be),
    .cpu_stall      (cpu_stall),
    .cpu_resp       (cpu_resp),
    .cpu_rdata      (cpu_rdata),
    .pa_valid       (pa_valid),
    .pa_addr        (pa_addr),
    .alias_fault    (alias_fault),
    .mem_addr       (mem_addr),
    .mem_wr_valid   (mem_wr_valid),
    .mem_wr_ready   (mem_wr_ready),
    .mem_wdata      (mem_wdata),
    .mem_fill_ready (mem_fill_ready),
    .mem_rd_valid   (mem_rd_valid),
    .mem_rd_data    (mem_rd_data),
    .tag_rd_en      (tag_rd_en),
    .tag_rd_idx     (tag_rd_idx),
    .tag_rd_valid   (tag_rd_valid),
    .tag_rd_dirty   (tag_rd_dirty),
    .tag_rd_tag     (tag_rd_tag),
    .tag_wr_en      (tag_wr_en),
    .tag_wr_idx     (tag_wr_idx),
    .tag_wr_tag     (tag_wr_tag),
    .tag_wr_dirty   (tag_wr_dirty),
    .line_rd_line   (line_rd_line),
    .line_wr_en     (line_wr_en),
    .line_wr_line   (line_wr_line)
  );

endmodule

// File: tb/tb_vipt_dcache.sv
`timescale 1ns/1ps
module tb_vipt_dcache;

  logic        clk;
  logic        rst_n;
  logic        cpu_req, cpu_we;
  logic [31:0] cpu_vaddr, cpu_wdata;
  logic [3:0]  cpu_be;
  logic        cpu_stall, cpu_resp;
  logic [31:0] cpu_rdata;
  logic        pa_valid;
  logic [31:0] pa_addr;
  logic        alias_fault;
  logic [31:0] mem_addr;
  logic        mem_wr_valid, mem_wr_ready;
  logic [31:0] mem_wdata;
  logic        mem_fill_ready, mem_rd_valid;
  logic [31:0] mem_rd_data;

  vipt_dcache dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_vaddr(cpu_vaddr),
    .cpu_wdata(cpu_wdata), .cpu_be(cpu_be),
    .cpu_stall(cpu_stall), .cpu_resp(cpu_resp), .cpu_rdata(cpu_rdata),
    .pa_valid(pa_valid), .pa_addr(pa_addr), .alias_fault(alias_fault),
    .mem_addr(mem_addr), .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
    .mem_wdata(mem_wdata), .mem_fill_ready(mem_fill_ready),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk; // 50 MHz

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // ---------------- flat models ----------------
  logic [31:0] ref_mem [bit [31:0]];
  logic [31:0] bk_mem  [bit [31:0]];

  function automatic logic [31:0] init_word(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A3C, a[31:16] ^ 16'hC3A5};
  endfunction
  function automatic logic [31:0] ref_rd(input logic [31:0] a);
    return ref_mem.exists(a) ? ref_mem[a] : init_word(a);
  endfunction
  function automatic logic [31:0] bk_rd(input logic [31:0] a);
    return bk_mem.exists(a) ? bk_mem[a] : init_word(a);
  endfunction

  // ---------------- memory model ----------------
  int wb_beat = 0, wb_cnt = 0, wb_total = 0;
  int fill_beat = 0, fill_cnt = 0;
  logic [31:0] last_wb_base = '0, last_fill_base = '0;
  bit wb_open_at_fill = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      mem_wr_ready = 1'b0;
      mem_rd_valid = 1'b0;
      mem_rd_data  = '0;
    end else begin
      mem_wr_ready = ($urandom % 4) != 0;
      if (mem_wr_valid && mem_wr_ready) begin
        bk_mem[mem_addr + 32'(wb_beat * 4)] = mem_wdata;
        wb_beat++;
        wb_total++;
        if (wb_beat == 16) begin
          wb_beat = 0;
          wb_cnt++;
          last_wb_base = mem_addr;
        end
      end
      if (mem_fill_ready && (($urandom % 3) != 0)) begin
        if (fill_beat == 0 && wb_beat != 0) wb_open_at_fill = 1;
        mem_rd_valid = 1'b1;
        mem_rd_data  = bk_rd(mem_addr + 32'(fill_beat * 4));
        fill_beat++;
        if (fill_beat == 16) begin
          fill_beat = 0;
          fill_cnt++;
          last_fill_base = mem_addr;
        end
      end else begin
        mem_rd_valid = 1'b0;
      end
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct {
    int          kind;   // 0 load, 1 store, 2 fault
    logic [31:0] data;
    string       req;
  } exp_item_t;

  exp_item_t exp_q[$];
  int done_cnt = 0;
  int resp_cyc = 0;

  always @(negedge clk) begin
    if (rst_n && (cpu_resp || alias_fault)) begin
      exp_item_t it;
      resp_cyc = cyc;
      if (exp_q.size() == 0) begin
        check(0, "R8 unexpected completion", {30'd0, alias_fault, cpu_resp}, 32'd0);
      end else begin
        it = exp_q.pop_front();
        if (it.kind == 2) begin
          check(alias_fault && !cpu_resp, it.req, {30'd0, alias_fault, cpu_resp}, 32'd2);
        end else if (it.kind == 1) begin
          check(cpu_resp && !alias_fault, it.req, {30'd0, alias_fault, cpu_resp}, 32'd1);
        end else begin
          check(cpu_resp && !alias_fault && cpu_rdata === it.data, it.req,
                cpu_rdata, it.data);
        end
      end
      done_cnt++;
    end
  end

  // ---------------- driver ----------------
  task automatic access(input logic [31:0] va, input logic [31:0] pa, input bit we,
                        input logic [31:0] wd, input logic [3:0] be, input int delay,
                        input bit exp_hit, input bit poke, input string req);
    exp_item_t it;
    int start, pa_cyc;
    logic [31:0] w, old;
    while (cpu_stall) @(negedge clk);
    w = {pa[31:2], 2'b00};
    it.req = req;
    it.data = '0;
    if (va[14:13] != pa[14:13]) begin
      it.kind = 2;
    end else if (we) begin
      it.kind = 1;
      old = ref_rd(w);
      for (int b = 0; b < 4; b++) if (be[b]) old[b*8 +: 8] = wd[b*8 +: 8];
      ref_mem[w] = old;
    end else begin
      it.kind = 0;
      it.data = ref_rd(w);
    end
    exp_q.push_back(it);
    start = done_cnt;
    cpu_req = 1; cpu_we = we; cpu_vaddr = va; cpu_wdata = wd; cpu_be = be;
    @(negedge clk);
    cpu_req = 0;
    check(cpu_stall == 1'b1, "R8 stall after accept", {31'd0, cpu_stall}, 32'd1);
    repeat (delay) @(negedge clk);
    pa_valid = 1; pa_addr = pa; pa_cyc = cyc;
    @(negedge clk);
    pa_valid = 0;
    if (poke) begin
      // request while stalled must be ignored (R8)
      cpu_req = 1; cpu_we = 1; cpu_vaddr = {va[31:6], 6'h04};
      cpu_wdata = 32'hDEAD_BEEF; cpu_be = 4'hF;
      @(negedge clk);
      cpu_req = 0;
    end
    while (done_cnt == start) @(negedge clk);
    if (exp_hit) check(resp_cyc - pa_cyc == 1, {req, " R2 hit latency"},
                       32'(resp_cyc - pa_cyc), 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog expired", 32'd0, 32'd1);
    summary();
  end

  initial begin
    int wb0, fill0, wbt0;
    rst_n = 0; cpu_req = 0; cpu_we = 0; cpu_vaddr = '0; cpu_wdata = '0;
    cpu_be = '0; pa_valid = 0; pa_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(cpu_stall == 0, "R1 stall", {31'd0, cpu_stall}, 0);
    check(cpu_resp == 0, "R1 resp", {31'd0, cpu_resp}, 0);
    check(alias_fault == 0, "R1 fault", {31'd0, alias_fault}, 0);
    check(mem_wr_valid == 0, "R1 wr_valid", {31'd0, mem_wr_valid}, 0);
    check(mem_fill_ready == 0, "R1 fill_ready", {31'd0, mem_fill_ready}, 0);

    // R6 clean miss then R2 hit
    fill0 = fill_cnt;
    access(32'h0000_2048, 32'h1234_2048, 0, 0, 0, 0, 0, 0, "R6 R10 load miss");
    check(fill_cnt == fill0 + 1, "R6 one fill", 32'(fill_cnt - fill0), 1);
    check(last_fill_base == 32'h1234_2040, "R6 fill base", last_fill_base, 32'h1234_2040);
    access(32'h0000_207C, 32'h1234_207C, 0, 0, 0, 2, 1, 0, "R2 load hit word 15");
    access(32'h0000_2040, 32'h1234_2040, 0, 0, 0, 1, 1, 0, "R2 load hit word 0");

    // R3 store hit with byte enables, no memory write
    wbt0 = wb_total;
    access(32'h0000_2048, 32'h1234_2048, 1, 32'hAABB_CCDD, 4'b0101, 0, 1, 0, "R3 store hit");
    access(32'h0000_2048, 32'h1234_2048, 0, 0, 0, 0, 1, 0, "R3 merged load");
    check(wb_total == wbt0, "R3 no memory write on store hit", 32'(wb_total - wbt0), 0);

    // R4 same color, other virtual page, same physical page
    access(32'h4000_2048, 32'h1234_2048, 0, 0, 0, 0, 1, 0, "R4 alias sees store");
    access(32'h4000_204C, 32'h1234_204C, 1, 32'h1357_9BDF, 4'hF, 3, 1, 0, "R4 alias store");
    access(32'h0000_204C, 32'h1234_204C, 0, 0, 0, 0, 1, 0, "R4 original sees alias store");

    // R5 color mismatch, then unchanged contents
    access(32'h0000_6048, 32'h1234_2048, 1, 32'hFFFF_FFFF, 4'hF, 0, 0, 0, "R5 color fault");
    access(32'h0000_204C, 32'h1234_2048 ^ 32'h0000_6004, 1, 32'h0, 4'hF, 1, 0, 0, "R5 color fault 2");
    access(32'h0000_2048, 32'h1234_2048, 0, 0, 0, 0, 1, 0, "R5 state unchanged");

    // R7 dirty eviction
    wb0 = wb_cnt; wb_open_at_fill = 0;
    access(32'h0000_2048, 32'h5678_2048, 0, 0, 0, 0, 0, 0, "R7 R10 conflict load");
    check(wb_cnt == wb0 + 1, "R7 one writeback", 32'(wb_cnt - wb0), 1);
    check(last_wb_base == 32'h1234_2040, "R7 writeback base", last_wb_base, 32'h1234_2040);
    check(wb_open_at_fill == 0, "R7 writeback before fill", {31'd0, wb_open_at_fill}, 0);
    wb0 = wb_cnt;
    access(32'h4000_2048, 32'h1234_2048, 0, 0, 0, 1, 0, 0, "R7 R10 reload written line");
    check(wb_cnt == wb0, "R7 clean victim not written", 32'(wb_cnt - wb0), 0);
    access(32'h4000_204C, 32'h1234_204C, 0, 0, 0, 0, 1, 0, "R7 reload word 3");

    // R9 store miss allocate, R8 request while stalled ignored
    fill0 = fill_cnt;
    access(32'h0000_8108, 32'h2222_0108, 1, 32'h0BAD_F00D, 4'b1110, 0, 0, 1, "R9 store miss");
    check(fill_cnt == fill0 + 1, "R9 store miss fills", 32'(fill_cnt - fill0), 1);
    access(32'h0000_8108, 32'h2222_0108, 0, 0, 0, 0, 1, 0, "R9 allocated store data");
    access(32'h0000_8104, 32'h2222_0104, 0, 0, 0, 0, 1, 0, "R8 stalled request ignored");
    wb0 = wb_cnt;
    access(32'h0000_8100, 32'h3333_0100, 0, 0, 0, 0, 0, 0, "R9 dirty after store miss");
    check(wb_cnt == wb0 + 1, "R9 line was dirty", 32'(wb_cnt - wb0), 1);

    // R10 mixed traffic against the flat model
    for (int n = 0; n < 250; n++) begin
      logic [31:0] pa, va;
      logic [1:0]  col, vcol;
      logic [6:0]  low;
      col  = 2'($urandom % 4);
      low  = 7'(($urandom % 3) * 5);
      pa   = {17'(32'h100 + ($urandom % 3)), col, low, 4'($urandom % 16), 2'b00};
      vcol = (($urandom % 10) == 0) ? ~col : col;
      va   = {17'($urandom), vcol, pa[12:0]};
      access(va, pa, ($urandom % 2) == 1, $urandom, 4'($urandom), int'($urandom % 3),
             0, 0, "R10 random traffic");
    end
    summary();
  end

endmodule